// File: doc/BRIEF.md
# Cell Balance Switch Interlock Controller

This block sits between the host register interface and the bleed switches of a six-cell battery stack. The host writes a request word with one bit per cell. The block keeps that word and filters it, then drives one switch-enable line per cell from a register. The filter is a hardware safety rule that the host cannot override. A switch is allowed to conduct only when neither of its immediate neighbours is requested in the same word. When two neighbouring bits are requested together, both members of the pair stay off. This keeps any cell input from seeing the voltage of two cells at once.

The host can read back both the raw request word and the word that was actually applied, so it can see which requests were suppressed. A conflict flag shows whether the most recent write contained at least one neighbouring pair. The bleed current, the power budget and the balancing policy are left to the host.

A small state machine tracks the applied state. It has three states:
- ST_IDLE: no switch is on and the last write had no conflict.
- ST_BALANCE: at least one switch is on and the last write had no conflict.
- ST_GUARD: the last write contained a neighbouring pair.

Every write takes a transition chosen by the written word:
- GO_GUARD: the word contains a neighbouring pair.
- GO_BALANCE: the filtered word is non-zero and has no pair.
- GO_IDLE: the word is zero.

Without a write, the machine follows the HOLD transition and stays where it is. Reset places the machine in ST_IDLE.

Top module: `cbal_switch_guard`

## Requirements
- R1: After reset, `sw_en`, `rd_applied` and `rd_req` are all zero and `conflict_flag` is 0.
- R2: A cycle with `wr_en` high stores `wr_data`, and `rd_req` shows that value from the next clock edge on.
- R3: A written word with no two set bits in neighbouring positions (bit n and bit n+1) appears unchanged on `sw_en` one clock after the write.
- R4: When bits n and n+1 are both written as 1, neither `sw_en[n]` nor `sw_en[n+1]` is 1 after the write.
- R5: Bit n of the applied word is set only when request bit n is 1 and request bits n-1 and n+1 are both 0. A position outside bits 0..5 counts as 0. A run of three set bits therefore gives three zeros, and a request bit 0 or bit 5 is blocked only by its single inner neighbour.
- R6: `rd_applied` always equals `sw_en`.
- R7: `sw_en` never has two neighbouring bits at 1 in any cycle.
- R8: `conflict_flag` is 1 after a write whose word contains a neighbouring pair, and 0 after a write whose word contains none.
- R9: While `wr_en` is low, `sw_en`, `rd_req` and `conflict_flag` keep their values, whatever `wr_data` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset that clears the register and turns off all switches |
| wr_en | input | 1 | Write strobe for the request word |
| wr_data | input | 6 | Request word, one bit per cell, bit 0 = lowest cell |
| rd_req | output | 6 | Stored raw request word |
| rd_applied | output | 6 | Applied word after interlock filtering |
| sw_en | output | 6 | Registered bleed switch enables |
| conflict_flag | output | 1 | Last write contained a neighbouring pair |

## Verification
The bench builds the block with its default of six cells. With six cells, all 64 request words can be written in turn and compared with an applied word that the bench computes bit by bit. The sweep covers every isolated pattern and every neighbouring pair. It also covers runs of three or more set bits and both end positions, where only one neighbour exists. Because the words are written in ascending order, the flag is driven both from clear to set and from set to clear many times.

// File: rtl/cbal_pkg.sv
package cbal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BALANCE = 2'd1,
        ST_GUARD   = 2'd2
    } cbal_state_e;

endpackage

// File: rtl/cbal_neighbor_filter.sv
module cbal_neighbor_filter #(
    parameter int N_CELLS = 6
) (
    input  logic [N_CELLS-1:0] req,
    output logic [N_CELLS-1:0] applied,
    output logic               conflict
);
    localparam int LAST = N_CELLS - 1;

    logic [N_CELLS-1:0] lower_nb;
    logic [N_CELLS-1:0] upper_nb;

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        if (i == 0) begin : g_bottom
            assign lower_nb[i] = 1'b0;
        end else begin : g_lower
            assign lower_nb[i] = req[i-1];
        end
        if (i == LAST) begin : g_top
            assign upper_nb[i] = 1'b0;
        end else begin : g_upper
            assign upper_nb[i] = req[i+1];
        end
        assign applied[i] = req[i] & ~lower_nb[i] & ~upper_nb[i];
    end

    assign conflict = |(req[LAST:1] & req[LAST-1:0]);

    always_comb begin
        AST_PAIR_BLOCKED: assert (!(conflict && (applied == req)))
            else $error("pair passed filter"); // R4
    end

endmodule

// File: rtl/cbal_ctrl_fsm.sv
module cbal_ctrl_fsm
    import cbal_pkg::*;
#(
    parameter int N_CELLS = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [N_CELLS-1:0] wr_data,
    input  logic [N_CELLS-1:0] filt_applied,
    input  logic               filt_conflict,
    output logic [N_CELLS-1:0] req_q,
    output logic [N_CELLS-1:0] app_q,
    output cbal_state_e        state_q
);
    cbal_state_e state_d;

    // Next-state selection: GO_GUARD, GO_BALANCE, GO_IDLE or HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_BALANCE, ST_GUARD: begin
                if (wr_en) begin
                    if (filt_conflict)
                        state_d = ST_GUARD;
                    else if (|filt_applied)
                        state_d = ST_BALANCE;
                    else
                        state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
            app_q <= '0;
        end else if (wr_en) begin
            req_q <= wr_data;
            app_q <= filt_applied;
        end
    end

    AST_STORE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (req_q == $past(wr_data))); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(app_q) && $stable(req_q) && $stable(state_q))); // R9

    AST_IDLE_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (app_q == '0)); // R5

endmodule

// File: rtl/cbal_switch_guard.sv
module cbal_switch_guard
    import cbal_pkg::*;
#(
    parameter int N_CELLS = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [N_CELLS-1:0] wr_data,
    output logic [N_CELLS-1:0] rd_req,
    output logic [N_CELLS-1:0] rd_applied,
    output logic [N_CELLS-1:0] sw_en,
    output logic               conflict_flag
);
    localparam int LAST = N_CELLS - 1;

    logic [N_CELLS-1:0] filt_applied;
    logic               filt_conflict;
    logic [N_CELLS-1:0] app_q;
    cbal_state_e        state_q;

    cbal_neighbor_filter #(.N_CELLS(N_CELLS)) u_filter (
        .req      (wr_data),
        .applied  (filt_applied),
        .conflict (filt_conflict)
    );

    cbal_ctrl_fsm #(.N_CELLS(N_CELLS)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .filt_applied  (filt_applied),
        .filt_conflict (filt_conflict),
        .req_q         (rd_req),
        .app_q         (app_q),
        .state_q       (state_q)
    );

    assign sw_en         = app_q;
    assign rd_applied    = app_q;
    assign conflict_flag = (state_q == ST_GUARD);

    AST_NO_NEIGHBOUR_ON: assert property (@(posedge clk) disable iff (!rst_n)
        ((sw_en[LAST:1] & sw_en[LAST-1:0]) == '0)); // R7

    AST_APPLIED_WITHIN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((sw_en & ~rd_req) == '0)); // R5

    AST_FLAG_ON_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((wr_data[LAST:1] & wr_data[LAST-1:0]) != '0)) |=> conflict_flag); // R8

endmodule

// File: tb/tb_cbal_switch_guard.sv
module tb_cbal_switch_guard;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [N-1:0] wr_data = '0;
    logic [N-1:0] rd_req, rd_applied, sw_en;
    logic         conflict_flag;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    cbal_switch_guard #(.N_CELLS(N)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_req(rd_req), .rd_applied(rd_applied), .sw_en(sw_en),
        .conflict_flag(conflict_flag)
    );

    function automatic logic [N-1:0] exp_applied(input logic [N-1:0] r);
        logic [N-1:0] e;
        for (int i = 0; i < N; i++) begin
            logic lo, hi;
            lo = (i > 0)     ? r[i-1] : 1'b0;
            hi = (i < N - 1) ? r[i+1] : 1'b0;
            e[i] = r[i] & ~lo & ~hi;
        end
        return e;
    endfunction

    function automatic logic exp_pair(input logic [N-1:0] r);
        logic p;
        p = 1'b0;
        for (int i = 0; i < N - 1; i++) p = p | (r[i] & r[i+1]);
        return p;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic write_word(input logic [N-1:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "sw_en", sw_en, '0);
        check("R1", "rd_applied", rd_applied, '0);
        check("R1", "rd_req", rd_req, '0);
        check("R1", "flag", {5'b0, conflict_flag}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // Exhaustive sweep of all request words
        for (int v = 0; v < (1 << N); v++) begin
            logic [N-1:0] w;
            w = N'(v);
            write_word(w);
            check("R2", "rd_req", rd_req, w);
            if (exp_pair(w))
                check("R4", "sw_en", sw_en, exp_applied(w));
            else
                check("R3", "sw_en", sw_en, w);
            check("R5", "sw_en rule", sw_en, exp_applied(w));
            check("R6", "rd_applied", rd_applied, sw_en);
            check("R7", "no neighbours", sw_en & (sw_en >> 1), '0);
            check("R8", "flag", {5'b0, conflict_flag}, {5'b0, exp_pair(w)});
        end

        // R5: run of three, and end cells with one neighbour
        write_word(6'b000111);
        check("R5", "run of three", sw_en, 6'b000000);
        write_word(6'b100001);
        check("R5", "both ends", sw_en, 6'b100001);
        write_word(6'b110000);
        check("R5", "top pair", sw_en, 6'b000000);

        // R8: flag set then cleared
        write_word(6'b011000);
        check("R8", "flag set", {5'b0, conflict_flag}, 6'b000001);
        write_word(6'b010100);
        check("R8", "flag clear", {5'b0, conflict_flag}, 6'b000000);

        // R9: no write, data toggling
        @(negedge clk);
        wr_data = 6'b111111;
        repeat (3) @(negedge clk);
        check("R9", "sw_en hold", sw_en, 6'b010100);
        check("R9", "rd_req hold", rd_req, 6'b010100);
        check("R9", "flag hold", {5'b0, conflict_flag}, 6'b000000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule